// File: doc/BRIEF.md
# Signed Sweep Counter with LED Sign-Magnitude Display

This block keeps a signed count that walks back and forth through the range -30 to +30 and shows it on eight LEDs. A prescaler divides the system clock, whose frequency is a parameter, into a step tick. The tick period is either half a second or one second, chosen by an input bit. On each tick, when enabled, the count moves one step. It goes up or down according to a direction input. Past either end of the range it wraps to the opposite end, so it never stops and never leaves the range.

The LED pattern uses the top bit as a sign flag. The seven lower bits carry the magnitude minus one, and a zero count lights nothing. A host design ties the clock, a synchronous reset and three level inputs to the block. It can take the signed count for other logic and send the LED vector to the board.

Top module: `sbc_sweep_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count loads -30 if `dir_up` is 1 and +30 if `dir_up` is 0, and the prescaler clears. The first step after reset release lands on the N-th rising edge with `rst` low, where N is the active tick period in clock cycles.
- R2: With `dir_up` = 1 and `en` = 1, each tick raises the count by one while it is below +30.
- R3: With `dir_up` = 1, a tick at +30 moves the count to -30.
- R4: With `dir_up` = 0 and `en` = 1, each tick lowers the count by one while it is above -30.
- R5: With `dir_up` = 0, a tick at -30 moves the count to +30.
- R6: With `fast_sel` = 1, ticks come every CLK_HZ/2 clock cycles (0.5 s).
- R7: With `fast_sel` = 0, ticks come every CLK_HZ clock cycles (1 s).
- R8: A change of `fast_sel` restarts the prescaler. The edge that sees the change produces no tick, and the next tick falls a full new period after that edge.
- R9: While `en` = 0, the count holds. The prescaler keeps running, so after `en` returns high the next step lands on the unchanged tick grid.
- R10: `led_o[7]` is 1 for a negative count and 0 otherwise. `led_o[6:0]` is the count's magnitude minus one, or 0 when the count is 0. For example, +8 gives 00000111 and -8 gives 10000111.
- R11: `count_o`, read as 7-bit two's complement, never lies outside -30 to +30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; count holds while low |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| fast_sel | input | 1 | 1 = 0.5 s step period, 0 = 1 s step period |
| count_o | output | COUNT_W (7) | Signed count, two's complement |
| led_o | output | LED_W (8) | Sign bit plus magnitude-minus-one LED code |

## Verification
The count register is the only storage between a tick and the outputs. A step therefore shows on `count_o` and `led_o` together, right after the N-th rising edge counted from reset release or from the edge that sees a period change. N is CLK_HZ/2 or CLK_HZ. The bench drives and samples on falling edges. It counts edges from each such reference point and checks the count one edge before a step is due and again on the edge it is due, so both an early step and a late step are caught. The LED code follows the count with no extra delay, so every count sample also checks the LED vector against a value the bench derives from the expected count.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   // Direction of travel for the sweep.
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;

   // Tick period choice.
   typedef enum logic {
      PER_SLOW = 1'b0,
      PER_FAST = 1'b1
   } period_e;

endpackage

// File: rtl/sbc_tick_gen.sv
module sbc_tick_gen #(
   parameter int unsigned CLK_HZ = 100_000_000
) (
   input  logic              clk,
   input  logic              rst,
   input  sbc_pkg::period_e  period_i,
   output logic              tick_o
);

   localparam int unsigned FAST_N = CLK_HZ / 2;
   localparam int unsigned SLOW_N = CLK_HZ;
   localparam int unsigned CW     = (SLOW_N > 2) ? $clog2(SLOW_N) : 1;
   localparam logic [CW-1:0] FAST_LIM = CW'(FAST_N - 1);
   localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_N - 1);
   localparam logic [CW-1:0] INC      = CW'(1);

   generate
      if (CLK_HZ < 2) begin : g_bad_clk
         $error("sbc_tick_gen: CLK_HZ must be at least 2");
      end
   endgenerate

   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     lim;
   sbc_pkg::period_e  period_q;
   logic              restart;

   always_comb begin
      lim     = (period_i == sbc_pkg::PER_FAST) ? FAST_LIM : SLOW_LIM;
      restart = (period_i != period_q);
      tick_o  = !restart && (cnt_q == lim);
   end

   always_ff @(posedge clk) begin
      period_q <= period_i;
      if (rst || restart || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + INC;
      end
   end

endmodule

// File: rtl/sbc_step_reg.sv
module sbc_step_reg #(
   parameter int unsigned COUNT_W = 7,
   parameter int unsigned LIMIT   = 30
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       adv_i,
   input  sbc_pkg::dir_e              dir_i,
   output logic signed [COUNT_W-1:0]  count_o
);

   localparam logic signed [COUNT_W-1:0] HI  = COUNT_W'(LIMIT);
   localparam logic signed [COUNT_W-1:0] LO  = -HI;
   localparam logic signed [COUNT_W-1:0] ONE = COUNT_W'(1);

   generate
      if (COUNT_W < 2) begin : g_bad_width
         $error("sbc_step_reg: COUNT_W must be at least 2");
      end
      if (LIMIT < 1 || LIMIT > (2 ** (COUNT_W - 1)) - 1) begin : g_bad_limit
         $error("sbc_step_reg: LIMIT must fit the signed count width");
      end
   endgenerate

   logic signed [COUNT_W-1:0] count_q;
   logic signed [COUNT_W-1:0] count_nx;

   // The limit test comes before the add, so no out-of-range value is formed.
   always_comb begin
      if (dir_i == sbc_pkg::DIR_UP) begin
         count_nx = (count_q == HI) ? LO : count_q + ONE;
      end else begin
         count_nx = (count_q == LO) ? HI : count_q - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= (dir_i == sbc_pkg::DIR_UP) ? LO : HI;
      end else if (adv_i) begin
         count_q <= count_nx;
      end
   end

   assign count_o = count_q;

endmodule

// File: rtl/sbc_led_enc.sv
module sbc_led_enc #(
   parameter int unsigned COUNT_W = 7,
   parameter int unsigned LED_W   = 8,
   parameter int unsigned LIMIT   = 30
) (
   input  logic signed [COUNT_W-1:0] count_i,
   output logic [LED_W-1:0]          led_o
);

   localparam logic [COUNT_W-1:0] U1 = COUNT_W'(1);

   generate
      if (LED_W < 2) begin : g_bad_led
         $error("sbc_led_enc: LED_W must be at least 2");
      end
      if ((LIMIT - 1) >= (2 ** (LED_W - 1))) begin : g_bad_fit
         $error("sbc_led_enc: magnitude code does not fit the LED field");
      end
   endgenerate

   logic               neg;
   logic [COUNT_W-1:0] mag;
   logic [COUNT_W-1:0] code;

   always_comb begin
      neg  = count_i[COUNT_W-1];
      mag  = neg ? (~$unsigned(count_i) + U1) : $unsigned(count_i);
      code = (mag == '0) ? '0 : mag - U1;
   end

   generate
      if (LED_W - 1 > COUNT_W) begin : g_pad
         assign led_o = {neg, {(LED_W - 1 - COUNT_W){1'b0}}, code};
      end else if (LED_W - 1 == COUNT_W) begin : g_exact
         assign led_o = {neg, code};
      end else begin : g_trunc
         assign led_o = {neg, code[LED_W-2:0]};
      end
   endgenerate

endmodule

// File: rtl/sbc_sweep_counter.sv
module sbc_sweep_counter #(
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned COUNT_W = 7,
   parameter int unsigned LIMIT   = 30,
   parameter int unsigned LED_W   = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   input  logic                      dir_up,
   input  logic                      fast_sel,
   output logic signed [COUNT_W-1:0] count_o,
   output logic [LED_W-1:0]          led_o
);

   logic step_tick;
   logic step_adv;

   sbc_tick_gen #(
      .CLK_HZ (CLK_HZ)
   ) u_tick (
      .clk      (clk),
      .rst      (rst),
      .period_i (sbc_pkg::period_e'(fast_sel)),
      .tick_o   (step_tick)
   );

   assign step_adv = step_tick & en;

   sbc_step_reg #(
      .COUNT_W (COUNT_W),
      .LIMIT   (LIMIT)
   ) u_step (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (step_adv),
      .dir_i   (sbc_pkg::dir_e'(dir_up)),
      .count_o (count_o)
   );

   sbc_led_enc #(
      .COUNT_W (COUNT_W),
      .LED_W   (LED_W),
      .LIMIT   (LIMIT)
   ) u_led (
      .count_i (count_o),
      .led_o   (led_o)
   );

endmodule

// File: rtl/sbc_sweep_counter_chk.sv
module sbc_sweep_counter_chk #(
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned COUNT_W = 7,
   parameter int unsigned LIMIT   = 30,
   parameter int unsigned LED_W   = 8
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      en,
   input logic                      dir_up,
   input logic                      fast_sel,
   input logic signed [COUNT_W-1:0] count,
   input logic [LED_W-1:0]          led,
   input logic                      step_tick
);

   localparam logic signed [COUNT_W-1:0] HI  = COUNT_W'(LIMIT);
   localparam logic signed [COUNT_W-1:0] LO  = -HI;
   localparam logic signed [COUNT_W-1:0] ONE = COUNT_W'(1);
   localparam int unsigned FAST_LIM = CLK_HZ / 2 - 1;
   localparam int unsigned SLOW_LIM = CLK_HZ - 1;

   // Independent cycle counter since the last tick, reset or period change.
   int unsigned gap_q;
   logic        sel_q;
   int unsigned lim_now;

   assign lim_now = fast_sel ? FAST_LIM : SLOW_LIM;

   always_ff @(posedge clk) begin
      sel_q <= fast_sel;
      if (rst || (fast_sel != sel_q) || step_tick) begin
         gap_q <= 0;
      end else begin
         gap_q <= gap_q + 1;
      end
   end

   a_r1_reset_load: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (count == ($past(dir_up) ? LO : HI)));

   a_r2_r3_up_step: assert property (@(posedge clk) disable iff (rst)
      (!$stable(count) && $past(!rst) && $past(dir_up))
         |-> (count == (($past(count) == HI) ? LO : $past(count) + ONE)));

   a_r4_r5_down_step: assert property (@(posedge clk) disable iff (rst)
      (!$stable(count) && $past(!rst) && $past(!dir_up))
         |-> (count == (($past(count) == LO) ? HI : $past(count) - ONE)));

   a_r6_r7_tick_due: assert property (@(posedge clk) disable iff (rst)
      ((fast_sel == sel_q) && (gap_q == lim_now)) |-> step_tick);

   a_r8_tick_not_early: assert property (@(posedge clk) disable iff (rst)
      step_tick |-> ((fast_sel == sel_q) && (gap_q == lim_now)));

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!en)) |-> $stable(count));

   a_r10_sign_bit: assert property (@(posedge clk) disable iff (rst)
      led[LED_W-1] == (count < 0));

   a_r10_dark_near_zero: assert property (@(posedge clk) disable iff (rst)
      ((count == 0) || (count == ONE) || (count == -ONE)) == (led[LED_W-2:0] == '0));

   a_r11_in_range: assert property (@(posedge clk) disable iff (rst)
      (count >= LO) && (count <= HI));

endmodule

bind sbc_sweep_counter sbc_sweep_counter_chk #(
   .CLK_HZ  (CLK_HZ),
   .COUNT_W (COUNT_W),
   .LIMIT   (LIMIT),
   .LED_W   (LED_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .dir_up    (dir_up),
   .fast_sel  (fast_sel),
   .count     (count_o),
   .led       (led_o),
   .step_tick (step_tick)
);

// File: tb/sbc_sweep_counter_test.sv
module sbc_sweep_counter_test;

   localparam int HZ = 20;
   localparam int NF = HZ / 2;
   localparam int NS = HZ;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       dir_up = 1'b1;
   logic       fast_sel = 1'b1;
   logic [6:0] count_o;
   logic [7:0] led_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sbc_sweep_counter #(
      .CLK_HZ  (HZ),
      .COUNT_W (7),
      .LIMIT   (30),
      .LED_W   (8)
   ) uut (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .dir_up   (dir_up),
      .fast_sel (fast_sel),
      .count_o  (count_o),
      .led_o    (led_o)
   );

   function automatic logic [7:0] led_of(int v);
      if (v < 0) return {1'b1, 7'(-v - 1)};
      else if (v == 0) return 8'h00;
      else return {1'b0, 7'(v - 1)};
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Count, LED (R10) and range (R11) together.
   task automatic chk_count(string req, int exp);
      int act;
      act = int'($signed(count_o));
      chk(act == exp, req, "count", act, exp);
      chk(led_o == led_of(exp), "R10", "led", int'(led_o), int'(led_of(exp)));
      chk(act >= -30 && act <= 30, "R11", "range", act, exp);
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply_reset(bit up, bit fast, bit enable);
      @(negedge clk);
      rst = 1'b1;
      dir_up = up;
      fast_sel = fast;
      en = enable;
      wait_n(2);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      apply_reset(1'b1, 1'b1, 1'b0);
      chk_count("R1", -30);
      apply_reset(1'b0, 1'b1, 1'b0);
      chk_count("R1", 30);
   endtask

   task automatic t_up_sweep();
      int e;
      apply_reset(1'b1, 1'b1, 1'b1);
      wait_n(NF - 1);
      chk_count("R1", -30);
      wait_n(1);
      chk_count("R6", -29);
      e = -29;
      for (int i = 0; i < 60; i++) begin
         int prev;
         prev = e;
         e = (e == 30) ? -30 : e + 1;
         wait_n(NF - 1);
         chk_count("R6", prev);
         wait_n(1);
         chk_count((prev == 30) ? "R3" : "R2", e);
      end
   endtask

   task automatic t_down_sweep();
      int e;
      apply_reset(1'b0, 1'b0, 1'b1);
      wait_n(NS - 1);
      chk_count("R7", 30);
      wait_n(1);
      chk_count("R7", 29);
      e = 29;
      for (int i = 0; i < 60; i++) begin
         int prev;
         prev = e;
         e = (e == -30) ? 30 : e - 1;
         wait_n(NS - 1);
         chk_count("R7", prev);
         wait_n(1);
         chk_count((prev == -30) ? "R5" : "R4", e);
      end
   endtask

   task automatic t_hold();
      apply_reset(1'b1, 1'b1, 1'b0);
      wait_n(10);
      chk_count("R9", -30);
      wait_n(15);
      en = 1'b1;
      wait_n(4);
      chk_count("R9", -30);
      wait_n(1);
      chk_count("R9", -29);
   endtask

   task automatic t_sel_change();
      apply_reset(1'b1, 1'b1, 1'b1);
      wait_n(5);
      fast_sel = 1'b0;
      wait_n(20);
      chk_count("R8", -30);
      wait_n(1);
      chk_count("R8", -29);
      fast_sel = 1'b1;
      wait_n(10);
      chk_count("R8", -29);
      wait_n(1);
      chk_count("R8", -28);
   endtask

   task automatic t_dir_flip();
      apply_reset(1'b1, 1'b1, 1'b1);
      wait_n(30);
      chk_count("R2", -27);
      dir_up = 1'b0;
      wait_n(10);
      chk_count("R4", -28);
   endtask

   initial begin
      t_reset();
      t_up_sweep();
      t_down_sweep();
      t_hold();
      t_sel_change();
      t_dir_flip();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run_complete actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule